// File: doc/BRIEF.md
# Time-Shared Dual-Winding Current Chopper

This block regulates the current in two motor windings with a single current-sense comparator. A phase-select output tells the external sense multiplexer which winding is being measured. The block divides an oscillator tick by two to form its chopping clock. On each chopping pulse it switches to the other winding, provided the winding it is leaving has already been turned off by a comparator trip. It then turns on the gate of the newly selected winding. The comparator trip turns the active gate off. The trip is first passed through a synchroniser and is ignored during a blanking window right after turn-on.

When both windings trip on time, each winding gets every other chopping pulse, so the time split is 50/50. If the active winding has not tripped by the next chopping pulse, the switch-over is deferred to the first pulse after its trip. The chopping period then stretches and the split becomes uneven (67/33 for a trip that is one pulse late). Once trips come on time again, plain alternation resumes. A winding whose enable is low keeps its gate off but still uses up its turn.

Top module: `chop_share_top`

## Requirements
- R1: While reset is asserted and right after it, both gates are low and phaseSel is 1. Encoding: phaseSel = 0 selects winding A, phaseSel = 1 selects winding B.
- R2: A chopping pulse occurs on every second oscTick, counted from reset. The first gate to turn on after reset is gateA, on the second oscTick. The gate rises on the clock edge that samples that tick.
- R3: On a chopping pulse, if the gate of the currently selected winding is low, phaseSel toggles and the gate of the newly selected winding goes high on that edge, provided its enable is high.
- R4: A high level on tripIn passes through a two-flop synchroniser. Once the blanking window has elapsed, it clears the selected winding's gate.
- R5: On a chopping pulse where the selected winding's gate is still high, phaseSel is held and the gate stays on. With a trip that is one pulse late, the next rise of gateB comes 4 oscTick periods after the rise of gateA.
- R6: For BLANK_CYC clock cycles after a gate turns on, trips are ignored. With tripIn held high, a gate stays high for exactly BLANK_CYC+1 cycles.
- R7: A low enable forces that winding's gate low one clock edge later. Its turn is still used: phaseSel keeps toggling on the pulses.
- R8: gateA and gateB are never high at the same time.
- R9: With on-time trips, gateB rises 2 oscTick periods after gateA, and gateA rises again 4 periods after its previous rise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| oscTick | input | 1 | One-cycle pulse per oscillator period |
| tripIn | input | 1 | Asynchronous comparator trip, high when current reaches the reference |
| enA | input | 1 | Enable for winding A |
| enB | input | 1 | Enable for winding B |
| gateA | output | 1 | Switch drive for winding A |
| gateB | output | 1 | Switch drive for winding B |
| phaseSel | output | 1 | Winding under regulation (0 = A, 1 = B) |

## Verification
The bench builds the block with BLANK_CYC = 4 and SYNC_STAGES = 2, and issues oscTick every 6 clocks, so one chopping period is 12 clocks. Since the blanking window plus the synchroniser latency is well short of that period, a single period can hold a trip that is ignored, a trip that is accepted, and the idle gap before the next pulse. This makes both the 50/50 alternation and the one-pulse deferral reachable within a few dozen cycles. Random trip densities, from always-high to never-high with occasional enable drops, exercise deferrals several pulses long against a cycle model.

// File: rtl/chop_pkg.sv
package chop_pkg;
  typedef struct packed {
    logic advance;
    logic setA;
    logic setB;
    logic clrA;
    logic clrB;
  } chopStrobes_t;
endpackage

// File: rtl/chop_ctrl.sv
module chop_ctrl
  import chop_pkg::*;
#(
  parameter int BLANK_CYC   = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         oscTick,
  input  logic         tripIn,
  input  logic         enA,
  input  logic         enB,
  input  logic         gateA,
  input  logic         gateB,
  input  logic         phaseSel,
  output chopStrobes_t st
);
  localparam int CNT_W = (BLANK_CYC < 1) ? 1 : $clog2(BLANK_CYC + 1);
  localparam logic [CNT_W-1:0] BLANK_LD = CNT_W'(BLANK_CYC);

  logic divQ;
  logic [SYNC_STAGES-1:0] syncQ;
  logic [CNT_W-1:0] blankCnt;
  logic chopPulse, activeOn, tripOk;

  // trip synchroniser chain
  for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_sync
    if (i == 0) begin : g_first
      always_ff @(posedge clk or negedge rstN)
        if (!rstN) syncQ[0] <= 1'b0;
        else       syncQ[0] <= tripIn;
    end else begin : g_next
      always_ff @(posedge clk or negedge rstN)
        if (!rstN) syncQ[i] <= 1'b0;
        else       syncQ[i] <= syncQ[i-1];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) divQ <= 1'b0;
    else if (oscTick) divQ <= ~divQ;
  end

  always_comb begin
    chopPulse  = oscTick & divQ;
    activeOn   = phaseSel ? gateB : gateA;
    tripOk     = syncQ[SYNC_STAGES-1] & (blankCnt == '0);
    st.advance = chopPulse & ~activeOn;
    st.setA    = st.advance & phaseSel & enA;
    st.setB    = st.advance & ~phaseSel & enB;
    st.clrA    = ~enA | (tripOk & ~phaseSel & gateA);
    st.clrB    = ~enB | (tripOk & phaseSel & gateB);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                blankCnt <= '0;
    else if (st.setA | st.setB) blankCnt <= BLANK_LD;
    else if (blankCnt != '0)  blankCnt <= blankCnt - 1'b1;
  end

  p_blank_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    (($fell(gateA) && $past(enA)) || ($fell(gateB) && $past(enB)))
      |-> ($past(blankCnt) == '0));

  p_disabled_off_r7: assert property (@(posedge clk) disable iff (!rstN)
    (!enA |=> !gateA) and (!enB |=> !gateB));
endmodule

// File: rtl/chop_dp.sv
module chop_dp
  import chop_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  chopStrobes_t st,
  output logic         gateA,
  output logic         gateB,
  output logic         phaseSel
);
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      gateA    <= 1'b0;
      gateB    <= 1'b0;
      phaseSel <= 1'b1;
    end else begin
      if (st.advance) phaseSel <= ~phaseSel;
      if (st.setA)      gateA <= 1'b1;
      else if (st.clrA) gateA <= 1'b0;
      if (st.setB)      gateB <= 1'b1;
      else if (st.clrB) gateB <= 1'b0;
    end
  end

  p_single_gate_r8: assert property (@(posedge clk) disable iff (!rstN)
    !(gateA && gateB));

  p_rise_selected_r3: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(gateA) |-> !phaseSel) and ($rose(gateB) |-> phaseSel));

  p_switch_idle_r5: assert property (@(posedge clk) disable iff (!rstN)
    (phaseSel != $past(phaseSel)) |-> $past(!gateA && !gateB));
endmodule

// File: rtl/chop_share_top.sv
module chop_share_top
  import chop_pkg::*;
#(
  parameter int BLANK_CYC   = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic oscTick,
  input  logic tripIn,
  input  logic enA,
  input  logic enB,
  output logic gateA,
  output logic gateB,
  output logic phaseSel
);
  chopStrobes_t st;

  chop_ctrl #(.BLANK_CYC(BLANK_CYC), .SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk(clk), .rstN(rstN), .oscTick(oscTick), .tripIn(tripIn),
    .enA(enA), .enB(enB), .gateA(gateA), .gateB(gateB),
    .phaseSel(phaseSel), .st(st)
  );

  chop_dp u_dp (
    .clk(clk), .rstN(rstN), .st(st),
    .gateA(gateA), .gateB(gateB), .phaseSel(phaseSel)
  );
endmodule

// File: tb/tb_chop_share_top.sv
module tb_chop_share_top;
  localparam int BLANK = 4;
  localparam int OSC_PER = 6;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic oscTick = 1'b0, tripIn = 1'b0, enA = 1'b0, enB = 1'b0;
  logic gateA, gateB, phaseSel;

  chop_share_top #(.BLANK_CYC(BLANK), .SYNC_STAGES(2)) dut (
    .clk(clk), .rstN(rstN), .oscTick(oscTick), .tripIn(tripIn),
    .enA(enA), .enB(enB), .gateA(gateA), .gateB(gateB), .phaseSel(phaseSel)
  );

  always #5 clk = ~clk;

  int nChk = 0, nBad = 0, cyc = 0, ticks = 0, oscCtr = 0;
  int riseCntA = 0, riseCntB = 0, lastRiseA = 0, lastRiseB = 0, lastLenA = 0, toggles = 0;
  bit prevA = 0, prevB = 0, prevPh = 1, rstReq = 0;
  bit mDiv, mS1, mS2, mGA, mGB, mPh;
  int mCnt;
  string curTag = "R1";

  task automatic checkVal(input string tag, input int act, input int exp);
    nChk++;
    if (act != exp) begin
      nBad++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // cycle model of the requirements
  task automatic modelStep(input bit osc, input bit trip, input bit ea, input bit eb);
    bit pulse, act, adv, tok, sA, sB, nGA, nGB;
    if (!rstReq) begin
      mDiv = 0; mS1 = 0; mS2 = 0; mGA = 0; mGB = 0; mPh = 1; mCnt = 0;
      return;
    end
    pulse = osc & mDiv;
    act = mPh ? mGB : mGA;
    adv = pulse & !act;
    tok = mS2 && (mCnt == 0);
    sA = adv & mPh & ea;
    sB = adv & !mPh & eb;
    nGA = sA ? 1'b1 : ((!ea || (tok && !mPh && mGA)) ? 1'b0 : mGA);
    nGB = sB ? 1'b1 : ((!eb || (tok && mPh && mGB)) ? 1'b0 : mGB);
    if (sA || sB) mCnt = BLANK; else if (mCnt != 0) mCnt--;
    if (adv) mPh = !mPh;
    mGA = nGA; mGB = nGB;
    if (osc) mDiv = !mDiv;
    mS2 = mS1; mS1 = trip;
  endtask

  task automatic step(input bit trip, input bit ea, input bit eb);
    bit osc;
    @(negedge clk);
    cyc++;
    nChk++;
    if (gateA !== mGA || gateB !== mGB || phaseSel !== mPh) begin
      nBad++;
      $display("FAIL %s cycle %0d: actual A=%b B=%b sel=%b expected A=%b B=%b sel=%b",
               curTag, cyc, gateA, gateB, phaseSel, mGA, mGB, mPh);
    end
    if (gateA && !prevA) begin riseCntA++; lastRiseA = cyc; end
    if (!gateA && prevA) lastLenA = cyc - lastRiseA;
    if (gateB && !prevB) begin riseCntB++; lastRiseB = cyc; end
    if (phaseSel !== prevPh) toggles++;
    prevA = gateA; prevB = gateB; prevPh = phaseSel;
    rstN = rstReq;
    if (!rstReq) begin osc = 0; oscCtr = 0; end
    else begin
      osc = (oscCtr == OSC_PER - 1);
      oscCtr = (oscCtr + 1) % OSC_PER;
      if (osc) ticks++;
    end
    oscTick = osc; tripIn = trip; enA = ea; enB = eb;
    modelStep(osc, trip, ea, eb);
  endtask

  initial begin
    #200us;
    nBad++;
    $display("FAIL watchdog expired at cycle %0d", cyc);
    $display("test done: total=%0d bad=%0d", nChk, nBad);
    $finish;
  end

  initial begin
    int c0, cb0, rA, rB, pct, t0;
    bit tr, ea, eb;
    void'($urandom(32'd7741));
    modelStep(0, 0, 0, 0);
    // R1: reset state
    curTag = "R1";
    repeat (3) step(0, 1, 1);
    checkVal("R1 gateA", gateA, 0);
    checkVal("R1 gateB", gateB, 0);
    checkVal("R1 phaseSel", phaseSel, 1);
    rstReq = 1;
    // R2: first turn-on is gateA on the second tick
    curTag = "R2";
    while (riseCntA == 0) step(1, 1, 1);
    checkVal("R2 ticks at first rise", ticks, 2);
    checkVal("R2 gateB never on before A", riseCntB, 0);
    // R9 and R6: on-time trips
    curTag = "R9";
    rA = lastRiseA; cb0 = riseCntB;
    while (riseCntB == cb0) step(1, 1, 1);
    checkVal("R9 B rise offset", lastRiseB - rA, 2 * OSC_PER);
    c0 = riseCntA;
    while (riseCntA == c0) step(1, 1, 1);
    checkVal("R9 A rise period", lastRiseA - rA, 4 * OSC_PER);
    checkVal("R6 on-time with trip held", lastLenA, BLANK + 1);
    // R5: one-pulse late trip
    curTag = "R5";
    c0 = riseCntA;
    while (riseCntA == c0) step(1, 1, 1);
    rA = lastRiseA; cb0 = riseCntB;
    repeat (15) step(0, 1, 1);
    checkVal("R5 gateA held over deferred pulse", gateA, 1);
    checkVal("R5 phaseSel held", phaseSel, 0);
    while (riseCntB == cb0) step(1, 1, 1);
    checkVal("R5 B rise after late trip", lastRiseB - rA, 4 * OSC_PER);
    // R6: short trip during blanking is ignored
    curTag = "R6";
    c0 = riseCntA;
    while (riseCntA == c0) step(1, 1, 1);
    t0 = cyc;
    step(1, 1, 1); step(0, 1, 1);
    repeat (BLANK + 2) step(0, 1, 1);
    checkVal("R6 gateA still on after blanked trip", gateA, 1);
    repeat (8) step(1, 1, 1);
    // R7: disabled winding
    curTag = "R7";
    cb0 = riseCntB; t0 = toggles;
    repeat (60) step(1, 1, 0);
    checkVal("R7 gateB never rose", riseCntB - cb0, 0);
    checkVal("R7 phaseSel kept toggling", (toggles - t0) >= 4, 1);
    c0 = riseCntA;
    while (riseCntA == c0) step(0, 1, 0);
    step(0, 0, 0);
    step(0, 1, 1);
    checkVal("R7 gateA off after enable drop", gateA, 0);
    // random mix
    curTag = "R3/R4/R8";
    for (int seg = 0; seg < 15; seg++) begin
      pct = $urandom % 101;
      for (int k = 0; k < 200; k++) begin
        tr = ($urandom % 100) < pct;
        ea = ($urandom % 100) >= 4;
        eb = ($urandom % 100) >= 4;
        step(tr, ea, eb);
        checkVal("R8 single gate", gateA & gateB, 0);
      end
    end
    $display("test done: total=%0d bad=%0d", nChk, nBad);
    $finish;
  end
endmodule